// File: doc/BRIEF.md
# Thread Group Issue Scheduler

This block keeps the bookkeeping for the thread groups of one block processor in a many-threaded shader. It has a fixed number of group slots, 64 by default. Each slot holds one group of threads that share a single program counter. A slot keeps the group's context: its slot number, the base address of its register space and its current program address. Software-side logic allocates a group by giving its starting program address and register base. The block places the group in the lowest free slot and records how old the group is relative to all other live groups.

At any time at most one group owns the execution unit. Each issue occupies the unit for a fixed number of cycles, four by default. During that time the block presents the group's context on its issue outputs. When the unit becomes free, the oldest group that is ready takes it. Per-group stall and resume inputs take a group out of contention and bring it back. The group keeps its context and its age while it is stalled. A completion input frees a slot for reuse.

Top module: `tgroup_sched`

## Requirements
- R1: When `alloc_valid` is high and `full` is low, `alloc_grant` is high in the same cycle and `alloc_slot` gives the lowest-numbered free slot. The group is stored in that slot with the given program address and register base at the next clock edge.
- R2: `full` is high exactly when all NUM_GROUPS slots hold a group. While `full` is high, `alloc_grant` stays low and an allocation request changes nothing.
- R3: When the execution unit becomes free, it is given to the ready group that was allocated earliest among all live groups. A group becomes ready at the edge after its allocation.
- R4: Each issue keeps `issue_valid` high for exactly ISSUE_CYCLES cycles with a constant context. `issue_first` is high only in the first of those cycles. A following issue starts in the very next cycle with no idle gap.
- R5: At the end of an issue, the group's program address becomes the old value plus one. If `branch_valid` is high in the last cycle of the issue, it becomes `branch_target` instead.
- R6: A `stall_req` bit for a ready group makes it stalled at the next edge. A group that is issuing finishes its current issue first. A stalled group is never issued, and its context is kept. `stall_req` has no effect on groups that are free or already stalled.
- R7: A `resume_req` bit for a stalled group makes it ready again. The group keeps the age it had at allocation, so it still wins against groups that were allocated later.
- R8: `done_valid` with `done_slot` naming a live group frees that slot at the next edge. If that group is issuing, its issue ends there. A completion that names a free slot is ignored.
- R9: After reset, no group is issuing, every slot is free and `full` is low.
- R10: The issue outputs carry the slot number, program address and register base of the group that is issuing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to place a new group |
| alloc_pc | input | PC_W | Starting program address of the new group |
| alloc_rbase | input | RB_W | Register space base of the new group |
| alloc_grant | output | 1 | Allocation accepted this cycle |
| alloc_slot | output | log2(NUM_GROUPS) | Slot the new group goes to |
| full | output | 1 | All slots hold a group |
| stall_req | input | NUM_GROUPS | Per-slot stall request |
| resume_req | input | NUM_GROUPS | Per-slot resume request |
| done_valid | input | 1 | Group completion |
| done_slot | input | log2(NUM_GROUPS) | Slot of the completing group |
| branch_valid | input | 1 | Replace the next program address of the issuing group |
| branch_target | input | PC_W | Replacement program address |
| issue_valid | output | 1 | A group owns the execution unit |
| issue_first | output | 1 | First cycle of the current issue |
| issue_slot | output | log2(NUM_GROUPS) | Slot of the issuing group |
| issue_pc | output | PC_W | Program address of the issuing group |
| issue_rbase | output | RB_W | Register base of the issuing group |

## Verification
The bench uses the default parameters: 64 slots, a four-cycle issue and 16-bit addresses. With these values the bench fills every slot, so the full flag, the refused allocation and the ignored completion of a free slot can all be reached. A four-cycle issue is short enough that the bench can hit the first and last cycle of an issue exactly. This lets it check a stall during an issue, a branch target in the last cycle, a completion that cuts an issue short, and back-to-back issues of one group. The slots are freed and reused in between, so age ordering is also checked after the ranks have been compacted.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE    = 2'd0,
    SLOT_READY   = 2'd1,
    SLOT_STALLED = 2'd2
  } slot_state_e;
endpackage

// File: rtl/tgs_slot_table.sv
module tgs_slot_table
  import tgs_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               alloc_fire,
  input  logic [IDX_W-1:0]                   alloc_idx,
  input  logic                               free_fire,
  input  logic [IDX_W-1:0]                   free_idx,
  input  logic [NUM_SLOTS-1:0]               stall_req,
  input  logic [NUM_SLOTS-1:0]               resume_req,
  output logic [NUM_SLOTS-1:0]               free_mask,
  output logic [NUM_SLOTS-1:0]               ready_mask,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]    rank,
  output logic [IDX_W-1:0]                   lowest_free,
  output logic                               full
);
  localparam int OCC_W = $clog2(NUM_SLOTS + 1);

  slot_state_e                      st_q [NUM_SLOTS];
  slot_state_e                      st_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0][IDX_W-1:0]  rk_q, rk_d;
  logic [OCC_W-1:0]                 occ_q, occ_d;
  logic [IDX_W-1:0]                 freed_rank, new_rank;

  assign freed_rank = rk_q[free_idx];
  assign new_rank   = IDX_W'(occ_q - OCC_W'(free_fire));

  // next state: per-slot state and dense age rank (0 = oldest)
  always_comb begin
    occ_d = occ_q + OCC_W'(alloc_fire) - OCC_W'(free_fire);
    for (int g = 0; g < NUM_SLOTS; g++) begin
      st_d[g] = st_q[g];
      rk_d[g] = rk_q[g];
      if (st_q[g] == SLOT_READY && stall_req[g])
        st_d[g] = SLOT_STALLED;
      else if (st_q[g] == SLOT_STALLED && resume_req[g])
        st_d[g] = SLOT_READY;
      if (free_fire && st_q[g] != SLOT_FREE && rk_q[g] > freed_rank)
        rk_d[g] = rk_q[g] - IDX_W'(1);
      if (free_fire && IDX_W'(g) == free_idx)
        st_d[g] = SLOT_FREE;
      if (alloc_fire && IDX_W'(g) == alloc_idx) begin
        st_d[g] = SLOT_READY;
        rk_d[g] = new_rank;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_SLOTS; g++) st_q[g] <= SLOT_FREE;
      rk_q  <= '0;
      occ_q <= '0;
    end else begin
      for (int g = 0; g < NUM_SLOTS; g++) st_q[g] <= st_d[g];
      rk_q  <= rk_d;
      occ_q <= occ_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    assign free_mask[g]  = (st_q[g] == SLOT_FREE);
    assign ready_mask[g] = (st_q[g] == SLOT_READY);
  end

  assign rank = rk_q;
  assign full = (occ_q == OCC_W'(NUM_SLOTS));

  always_comb begin
    lowest_free = '0;
    for (int g = NUM_SLOTS - 1; g >= 0; g--)
      if (free_mask[g]) lowest_free = IDX_W'(g);
  end

  logic [NUM_SLOTS-1:0] oldest_mask;
  always_comb
    for (int g = 0; g < NUM_SLOTS; g++)
      oldest_mask[g] = (st_q[g] != SLOT_FREE) && (rk_q[g] == '0);

  // R3
  oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_mask) == ((occ_q != '0) ? 1 : 0));
  // R2
  occ_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q == OCC_W'($countones(~free_mask)));
  // R1
  alloc_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> free_mask[alloc_idx]);
endmodule

// File: rtl/tgs_oldest_pick.sv
module tgs_oldest_pick #(
  parameter int NUM_SLOTS = 64,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SLOTS-1:0]            eligible,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0] rank,
  output logic                            pick_valid,
  output logic [IDX_W-1:0]                pick_idx
);
  logic [IDX_W-1:0] best;

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    best       = '1;
    for (int g = 0; g < NUM_SLOTS; g++) begin
      if (eligible[g] && (!pick_valid || rank[g] < best)) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(g);
        best       = rank[g];
      end
    end
  end

  // R3
  pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> eligible[pick_idx]);
  // R3
  pick_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eligible) |-> pick_valid);
endmodule

// File: rtl/tgs_ctx_store.sv
module tgs_ctx_store #(
  parameter int NUM_SLOTS = 64,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter int PC_W      = 16,
  parameter int RB_W      = 16
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [RB_W-1:0]  wr_rb,
  input  logic             adv_en,
  input  logic [IDX_W-1:0] adv_idx,
  input  logic             adv_branch,
  input  logic [PC_W-1:0]  adv_target,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_pc,
  output logic [RB_W-1:0]  rd_rb
);
  logic [PC_W-1:0] pc_q [NUM_SLOTS];
  logic [RB_W-1:0] rb_q [NUM_SLOTS];
  logic [PC_W-1:0] adv_pc;

  assign adv_pc = adv_branch ? adv_target : pc_q[adv_idx] + PC_W'(1);

  always_ff @(posedge clk) begin
    for (int g = 0; g < NUM_SLOTS; g++) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        pc_q[g] <= wr_pc;
        rb_q[g] <= wr_rb;
      end else if (adv_en && adv_idx == IDX_W'(g)) begin
        pc_q[g] <= adv_pc;
      end
    end
  end

  assign rd_pc = pc_q[rd_idx];
  assign rd_rb = rb_q[rd_idx];
endmodule

// File: rtl/tgroup_sched.sv
module tgroup_sched #(
  parameter int NUM_GROUPS   = 64,
  parameter int PC_W         = 16,
  parameter int RB_W         = 16,
  parameter int ISSUE_CYCLES = 4,
  parameter int IDX_W        = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  input  logic [PC_W-1:0]       alloc_pc,
  input  logic [RB_W-1:0]       alloc_rbase,
  output logic                  alloc_grant,
  output logic [IDX_W-1:0]      alloc_slot,
  output logic                  full,
  input  logic [NUM_GROUPS-1:0] stall_req,
  input  logic [NUM_GROUPS-1:0] resume_req,
  input  logic                  done_valid,
  input  logic [IDX_W-1:0]      done_slot,
  input  logic                  branch_valid,
  input  logic [PC_W-1:0]       branch_target,
  output logic                  issue_valid,
  output logic                  issue_first,
  output logic [IDX_W-1:0]      issue_slot,
  output logic [PC_W-1:0]       issue_pc,
  output logic [RB_W-1:0]       issue_rbase
);
  localparam int CNT_W = (ISSUE_CYCLES > 1) ? $clog2(ISSUE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ISSUE_CYCLES - 1);

  logic [NUM_GROUPS-1:0]            free_mask, ready_mask, done_mask, eligible;
  logic [NUM_GROUPS-1:0][IDX_W-1:0] rank;
  logic                             pick_valid, done_fire, slot_last, kill_cur, pick_now;
  logic [IDX_W-1:0]                 pick_idx, lowest_free;
  logic                             active_q, active_d;
  logic [CNT_W-1:0]                 cnt_q, cnt_d;
  logic [IDX_W-1:0]                 cur_q, cur_d;

  assign alloc_grant = alloc_valid && !full;
  assign alloc_slot  = lowest_free;
  assign done_fire   = done_valid && !free_mask[done_slot];
  assign done_mask   = done_fire ? (NUM_GROUPS'(1) << done_slot) : '0;
  assign eligible    = ready_mask & ~stall_req & ~done_mask;
  assign slot_last   = active_q && (cnt_q == LAST);
  assign kill_cur    = done_fire && active_q && (done_slot == cur_q);
  assign pick_now    = !active_q || slot_last || kill_cur;

  tgs_slot_table #(.NUM_SLOTS(NUM_GROUPS), .IDX_W(IDX_W)) i_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_grant), .alloc_idx(lowest_free),
    .free_fire(done_fire), .free_idx(done_slot),
    .stall_req(stall_req), .resume_req(resume_req),
    .free_mask(free_mask), .ready_mask(ready_mask), .rank(rank),
    .lowest_free(lowest_free), .full(full)
  );

  tgs_oldest_pick #(.NUM_SLOTS(NUM_GROUPS), .IDX_W(IDX_W)) i_pick (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .rank(rank),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  tgs_ctx_store #(.NUM_SLOTS(NUM_GROUPS), .IDX_W(IDX_W), .PC_W(PC_W), .RB_W(RB_W)) i_ctx (
    .clk(clk),
    .wr_en(alloc_grant), .wr_idx(lowest_free), .wr_pc(alloc_pc), .wr_rb(alloc_rbase),
    .adv_en(slot_last && !kill_cur), .adv_idx(cur_q),
    .adv_branch(branch_valid), .adv_target(branch_target),
    .rd_idx(cur_q), .rd_pc(issue_pc), .rd_rb(issue_rbase)
  );

  // issue timer next state
  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    cur_d    = cur_q;
    if (pick_now) begin
      active_d = pick_valid;
      cnt_d    = '0;
      if (pick_valid) cur_d = pick_idx;
    end else if (active_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cur_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      cur_q    <= cur_d;
    end
  end

  assign issue_valid = active_q;
  assign issue_first = active_q && (cnt_q == '0);
  assign issue_slot  = cur_q;

  // R4
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_first) |-> (issue_slot == $past(issue_slot)));
  // R6
  issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_first |-> ready_mask[issue_slot]);
  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_first && $past(issue_valid) && $past(issue_slot) == issue_slot && !$past(branch_valid))
      |-> (issue_pc == $past(issue_pc) + PC_W'(1)));
endmodule

// File: tb/test_tgroup_sched.sv
`timescale 1ns/1ps
module test_tgroup_sched;
  localparam int N = 64, IW = 6, PW = 16, RW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          alloc_valid = 1'b0, alloc_grant, full;
  logic [PW-1:0] alloc_pc = '0;
  logic [RW-1:0] alloc_rbase = '0;
  logic [IW-1:0] alloc_slot;
  logic [N-1:0]  stall_req = '0, resume_req = '0;
  logic          done_valid = 1'b0;
  logic [IW-1:0] done_slot = '0;
  logic          branch_valid = 1'b0;
  logic [PW-1:0] branch_target = '0;
  logic          issue_valid, issue_first;
  logic [IW-1:0] issue_slot;
  logic [PW-1:0] issue_pc;
  logic [RW-1:0] issue_rbase;

  int checks = 0, errors = 0;

  typedef struct { int slot; int pc; int rb; string req; } exp_t;
  exp_t exp_q [$];

  always #2.5 clk = ~clk;

  tgroup_sched i_tgroup_sched (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_rbase(alloc_rbase),
    .alloc_grant(alloc_grant), .alloc_slot(alloc_slot), .full(full),
    .stall_req(stall_req), .resume_req(resume_req),
    .done_valid(done_valid), .done_slot(done_slot),
    .branch_valid(branch_valid), .branch_target(branch_target),
    .issue_valid(issue_valid), .issue_first(issue_first), .issue_slot(issue_slot),
    .issue_pc(issue_pc), .issue_rbase(issue_rbase)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every issue start against the scoreboard
  always @(negedge clk) begin
    if (rst_n && issue_first) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected issue of slot", issue_slot, 'hff);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(issue_slot) == e.slot, e.req, "issue slot (R3)", issue_slot, e.slot);
        chk(int'(issue_pc) == e.pc, e.req, "issue pc (R5)", issue_pc, e.pc);
        chk(int'(issue_rbase) == e.rb, e.req, "issue rbase (R10)", issue_rbase, e.rb);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_issue(input int slot, input int pc, input int rb, input string req);
    exp_t e;
    e.slot = slot; e.pc = pc; e.rb = rb; e.req = req;
    exp_q.push_back(e);
  endtask

  // allocate a group, then stall it before it can be picked
  task automatic alloc_park(input logic [PW-1:0] pc, input logic [RW-1:0] rb, input int slot);
    alloc_valid = 1'b1; alloc_pc = pc; alloc_rbase = rb;
    @(negedge clk);
    chk(alloc_grant == 1'b1, "R1", "alloc grant", alloc_grant, 1);
    chk(int'(alloc_slot) == slot, "R1", "alloc lowest free slot", alloc_slot, slot);
    tick();
    alloc_valid = 1'b0;
    stall_req[slot] = 1'b1;
    tick();
    stall_req = '0;
  endtask

  task automatic resume_grp(input logic [N-1:0] mask);
    resume_req = mask;
    tick();
    resume_req = '0;
  endtask

  task automatic wait_first();
    do @(negedge clk); while (!issue_first);
  endtask

  // stall whichever group starts issuing next, during its first cycle
  task automatic park_next();
    wait_first();
    stall_req[issue_slot] = 1'b1;
    tick();
    stall_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(issue_valid == 1'b0, "R9", "issue_valid after reset", issue_valid, 0);
    chk(full == 1'b0, "R9", "full after reset", full, 0);
    chk(alloc_slot == '0, "R9", "first free slot", alloc_slot, 0);
    tick();

    alloc_park(16'h0100, 16'h0040, 0);
    alloc_park(16'h0200, 16'h0080, 1);
    alloc_park(16'h0300, 16'h00c0, 2);
    repeat (6) tick();
    chk(issue_valid == 1'b0, "R6", "parked groups idle", issue_valid, 0);

    // R3 older group first; R6 stall ends after current issue
    expect_issue(1, 'h200, 'h80, "R3");
    expect_issue(2, 'h300, 'hc0, "R6");
    resume_grp(N'(6));
    park_next();
    park_next();
    repeat (10) tick();
    chk(issue_valid == 1'b0, "R6", "stalled groups not issued", issue_valid, 0);

    // R7 resumed group keeps its age: slot 0 beats slot 2
    expect_issue(0, 'h100, 'h40, "R7");
    expect_issue(2, 'h301, 'hc0, "R7");
    resume_grp(N'(5));
    park_next();
    park_next();
    repeat (4) tick();

    // R5 branch target in the last cycle of the issue
    expect_issue(0, 'h101, 'h40, "R5");
    resume_grp(N'(1));
    wait_first();
    stall_req[0] = 1'b1;
    tick();
    stall_req = '0;
    tick(); tick();
    branch_valid = 1'b1; branch_target = 16'h0500;
    tick();
    branch_valid = 1'b0;
    repeat (3) tick();
    expect_issue(0, 'h500, 'h40, "R5");
    resume_grp(N'(1));
    park_next();
    repeat (4) tick();

    // R4 back-to-back issues of one group, R8 completion cuts it short
    expect_issue(1, 'h201, 'h80, "R4");
    expect_issue(1, 'h202, 'h80, "R4");
    expect_issue(1, 'h203, 'h80, "R4");
    resume_grp(N'(2));
    wait_first();
    repeat (4) @(negedge clk);
    chk(issue_first && issue_pc == 16'h0202, "R4", "next issue after exactly 4 cycles", issue_pc, 'h202);
    repeat (4) @(negedge clk);
    chk(issue_first == 1'b1, "R4", "third issue start", issue_first, 1);
    done_valid = 1'b1; done_slot = 6'd1;
    tick();
    done_valid = 1'b0;
    @(negedge clk);
    chk(issue_valid == 1'b0, "R8", "issue ended by completion", issue_valid, 0);
    tick();

    // R8 freed slot reused; R3 age order after rank compaction
    alloc_park(16'h0700, 16'h0100, 1);
    expect_issue(2, 'h302, 'hc0, "R3");
    expect_issue(1, 'h700, 'h100, "R3");
    resume_grp(N'(6));
    park_next();
    park_next();
    repeat (4) tick();

    // R2 fill every slot
    for (int i = 3; i < N; i++) alloc_park(PW'(16'h1000 + i), RW'(i * 64), i);
    @(negedge clk);
    chk(full == 1'b1, "R2", "full with all slots used", full, 1);
    alloc_valid = 1'b1;
    @(negedge clk);
    chk(alloc_grant == 1'b0, "R2", "alloc refused when full", alloc_grant, 0);
    tick();
    alloc_valid = 1'b0;
    @(negedge clk);
    chk(full == 1'b1, "R2", "refused alloc changes nothing", full, 1);
    done_valid = 1'b1; done_slot = 6'd5;
    tick();
    done_valid = 1'b0;
    @(negedge clk);
    chk(full == 1'b0, "R8", "completion frees a slot", full, 0);
    // R8 completion of a free slot is ignored
    done_valid = 1'b1; done_slot = 6'd5;
    tick();
    done_valid = 1'b0;
    alloc_park(16'h2000, 16'h0000, 5);
    @(negedge clk);
    chk(full == 1'b1, "R8", "done on free slot ignored", full, 1);

    repeat (20) tick();
    chk(issue_valid == 1'b0, "R6", "no stalled group issued", issue_valid, 0);
    chk(exp_q.size() == 0, "R3", "expected issues left over", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule